// File: doc/BRIEF.md
# Recording Run Write-Gate Sequencer

This block decides, channel bit by channel bit, when the laser write gate is open for one recording run. A run covers M error-correction blocks of 16 physical sectors each. The block receives a start request with a physical sector number, the block count M, a flag that says whether the block before the target has already been recorded, and a small signed start trim. It then waits for the ADIP word that carries the matching address. Inside that word it opens the gate at a fixed wobble position, and it holds the gate open for the exact length of the run.

The channel-bit clock is assumed to be phase-locked to the wobble. An external counter supplies the wobble index within the current ADIP word and the bit phase within the wobble. It also supplies a word-sync strobe, together with the decoded address, on the first bit of each word. The first 8 bits of the open window carry linking bits, shown by a separate window output. The last 8 bits of the final sector are cut off. When the preceding block is missing, the run grows by one zero-filled block in front, and the block flags that block so the modulator can supply the zeros. Requests that cannot be honoured, and targets that never arrive, raise a sticky error and leave the gate closed.

Top module: `wgate_seq_top`

## Requirements
- R1: A request is refused when any of these holds: the start sector number is not a multiple of 16 (its 4 low bits are not zero), the block count is 0, or the trim lies outside -5..+5. A refused request raises errFlag one cycle later and never opens writeGate.
- R2: After an accepted request, the gate opens only inside the ADIP word whose address equals the start sector number shifted right by 2, or that value minus 4 when a dummy block is added.
- R3: writeGate is first high in the cycle in which wobbleNum reads 15 and wobblePhase reads 24 + trim (16 bits to the middle of the wobble, plus 8).
- R4: linkWindow is high for exactly the first 8 cycles of every open gate and never while the gate is closed.
- R5: The gate stays open for exactly (blocks × block length) consecutive cycles: 8 linking bits plus all blocks minus the final 8 bits. The block length is 4 words × wobbles per word × 32 bits.
- R6: With prevRecorded low, the run carries M+1 blocks and dummyReq is high for the one block length that directly follows the linking window. With prevRecorded high, dummyReq never rises.
- R7: If the configured number of word syncs (the timeout) pass without the target address, errFlag rises, the request is dropped and the gate stays closed.
- R8: A start request that arrives while a request is pending or a run is in progress has no effect on the current run and starts no later run.
- R9: After reset writeGate, linkWindow, dummyReq and errFlag are all low.
- R10: An accepted request clears errFlag in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel-bit clock, phase-locked to the wobble |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | One-cycle request to start a run |
| startPsn | input | PSN_W | Physical sector number of the first data block |
| blockCount | input | CNT_W | Number of data blocks M in the run |
| prevRecorded | input | 1 | High when the block before the first one is already on the disk |
| startTrim | input | TRIM_W | Signed offset of the start in channel bits |
| wobbleNum | input | clog2(WORD_WOBBLES) | Wobble index within the current ADIP word |
| wobblePhase | input | clog2(WOB_BITS) | Channel-bit phase within the current wobble |
| wordSync | input | 1 | High on the first channel bit of each ADIP word |
| adipAddr | input | PSN_W-2 | Decoded address of the current ADIP word |
| writeGate | output | 1 | Laser write enable |
| linkWindow | output | 1 | High while the linking bits are written |
| dummyReq | output | 1 | High while the zero-filled lead block is written |
| errFlag | output | 1 | Sticky refusal or timeout indication |

## Verification
The hardest situation to reach from the ports is the exact start bit: it needs a correct address, the right wobble and a trimmed phase, all at once. The bench therefore runs a free wobble and word counter whose addresses keep rising. Each request targets an aligned word two to five words ahead, with trims at both tolerance edges and with and without a dummy block. For every opening it records the counter values and the lengths of the gate, linking and dummy windows. Timeouts are reached by targeting an address that has already passed. A second request is injected in the middle of a run to show it is ignored.

// File: rtl/wgate_pkg.sv
package wgate_pkg;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ARMED = 2'd1,
    S_ALIGN = 2'd2,
    S_WRITE = 2'd3
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic clrTo;
    logic incTo;
    logic clrRun;
    logic incRun;
  } seqCtl_t;

  // conditions from datapath to control
  typedef struct packed {
    logic paramBad;
    logic wordSeen;
    logic addrHit;
    logic posHit;
    logic runLast;
    logic toLast;
  } seqFlag_t;

endpackage

// File: rtl/wgate_datapath.sv
module wgate_datapath
  import wgate_pkg::*;
#(
  parameter int WOB_BITS         = 32,
  parameter int WORD_WOBBLES     = 4836,
  parameter int WORDS_PER_BLOCK  = 4,
  parameter int SECTORS_PER_WORD = 4,
  parameter int LINK_BITS        = 8,
  parameter int CUT_BITS         = 8,
  parameter int START_WOBBLE     = 15,
  parameter int TRIM_TOL         = 5,
  parameter int TIMEOUT_WORDS    = 64,
  parameter int PSN_W            = 24,
  parameter int CNT_W            = 8,
  parameter int TRIM_W           = 5
) (
  input  logic                                       clk,
  input  logic                                       rstN,
  input  seqCtl_t                                    ctl,
  input  logic [PSN_W-1:0]                           startPsn,
  input  logic [CNT_W-1:0]                           blockCount,
  input  logic                                       prevRecorded,
  input  logic signed [TRIM_W-1:0]                   startTrim,
  input  logic [$clog2(WORD_WOBBLES)-1:0]            wobbleNum,
  input  logic [$clog2(WOB_BITS)-1:0]                wobblePhase,
  input  logic                                       wordSync,
  input  logic [PSN_W-$clog2(SECTORS_PER_WORD)-1:0]  adipAddr,
  input  logic                                       writing,
  output seqFlag_t                                   flags,
  output logic                                       linkWindow,
  output logic                                       dummyReq
);

  localparam int WORD_SH    = $clog2(SECTORS_PER_WORD);
  localparam int ADDR_W     = PSN_W - WORD_SH;
  localparam int SECT_LOW   = $clog2(SECTORS_PER_WORD * WORDS_PER_BLOCK);
  localparam int WNUM_W     = $clog2(WORD_WOBBLES);
  localparam longint BLOCK_BITS = longint'(WOB_BITS) * WORD_WOBBLES * WORDS_PER_BLOCK;
  localparam longint MAX_RUN    = (longint'(1) << CNT_W) * BLOCK_BITS + LINK_BITS;
  localparam int RUN_W      = $clog2(MAX_RUN + 1);
  localparam int TO_W       = $clog2(TIMEOUT_WORDS + 1);
  localparam int NOM_M1     = WOB_BITS / 2 + LINK_BITS - 1;
  localparam logic signed [TRIM_W-1:0] TOL_P = TRIM_W'(TRIM_TOL);
  localparam logic signed [TRIM_W-1:0] TOL_N = -TOL_P;

  logic [ADDR_W-1:0]         tgtAddr;
  logic [RUN_W-1:0]          runLen;
  logic [RUN_W-1:0]          runCnt;
  logic [TO_W-1:0]           toCnt;
  logic                      extReg;
  logic signed [TRIM_W-1:0]  trimReg;

  logic [ADDR_W-1:0]         psnWord;
  logic [ADDR_W-1:0]         tgtNext;
  logic [CNT_W:0]            blocksTot;
  logic [RUN_W-1:0]          runLenNext;
  int                        phaseTgt;

  always_comb begin
    psnWord    = startPsn[PSN_W-1:WORD_SH];
    tgtNext    = prevRecorded ? psnWord : psnWord - ADDR_W'(WORDS_PER_BLOCK);
    blocksTot  = {1'b0, blockCount} + {{CNT_W{1'b0}}, ~prevRecorded};
    runLenNext = RUN_W'(blocksTot) * RUN_W'(BLOCK_BITS)
               + RUN_W'(LINK_BITS) - RUN_W'(CUT_BITS) - RUN_W'(1);
    phaseTgt   = NOM_M1 + int'(trimReg);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tgtAddr <= '0;
      runLen  <= '0;
      extReg  <= 1'b0;
      trimReg <= '0;
    end else if (ctl.load) begin
      tgtAddr <= tgtNext;
      runLen  <= runLenNext;
      extReg  <= ~prevRecorded;
      trimReg <= startTrim;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           toCnt <= '0;
    else if (ctl.clrTo)  toCnt <= '0;
    else if (ctl.incTo)  toCnt <= toCnt + TO_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN)           runCnt <= '0;
    else if (ctl.clrRun) runCnt <= '0;
    else if (ctl.incRun) runCnt <= runCnt + RUN_W'(1);
  end

  always_comb begin
    flags.paramBad = (startPsn[SECT_LOW-1:0] != '0) || (blockCount == '0)
                   || (startTrim > TOL_P) || (startTrim < TOL_N);
    flags.wordSeen = wordSync;
    flags.addrHit  = wordSync && (adipAddr == tgtAddr);
    flags.posHit   = (wobbleNum == WNUM_W'(START_WOBBLE)) && (int'(wobblePhase) == phaseTgt);
    flags.runLast  = (runCnt == runLen);
    flags.toLast   = (toCnt == TO_W'(TIMEOUT_WORDS - 1));
  end

  assign linkWindow = writing && (runCnt < RUN_W'(LINK_BITS));
  assign dummyReq   = writing && extReg && (runCnt >= RUN_W'(LINK_BITS))
                    && (runCnt < RUN_W'(LINK_BITS + BLOCK_BITS));

  // gate must open on the bit right after the trimmed decision point
  p_open_pos_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(writing) |-> (($past(wobbleNum) == WNUM_W'(START_WOBBLE))
                        && (int'($past(wobblePhase)) == NOM_M1 + int'(trimReg))));

  // the run counter never passes the terminal count while writing
  p_run_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    writing |-> (runCnt <= runLen));

endmodule

// File: rtl/wgate_ctrl.sv
module wgate_ctrl
  import wgate_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     startReq,
  input  seqFlag_t flags,
  output seqCtl_t  ctl,
  output logic     writeGate,
  output logic     errFlag
);

  seqState_t state, stateNext;
  logic      errNext;

  always_comb begin
    stateNext = state;
    errNext   = errFlag;
    ctl       = '0;
    unique case (state)
      S_IDLE: begin
        if (startReq) begin
          ctl.load  = 1'b1;
          ctl.clrTo = 1'b1;
          if (flags.paramBad) begin
            errNext = 1'b1;
          end else begin
            errNext   = 1'b0;
            stateNext = S_ARMED;
          end
        end
      end
      S_ARMED: begin
        if (flags.addrHit) begin
          stateNext = S_ALIGN;
        end else if (flags.wordSeen) begin
          if (flags.toLast) begin
            errNext   = 1'b1;
            stateNext = S_IDLE;
          end else begin
            ctl.incTo = 1'b1;
          end
        end
      end
      S_ALIGN: begin
        if (flags.posHit) begin
          ctl.clrRun = 1'b1;
          stateNext  = S_WRITE;
        end
      end
      S_WRITE: begin
        if (flags.runLast) stateNext = S_IDLE;
        else               ctl.incRun = 1'b1;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      errFlag <= 1'b0;
    end else begin
      state   <= stateNext;
      errFlag <= errNext;
    end
  end

  assign writeGate = (state == S_WRITE);

  // a refused or timed-out request never leaves the gate open
  p_err_closed_r1: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> !writeGate);

  // a request seen while busy leaves the running state untouched
  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && (state == S_WRITE) && !flags.runLast) |=> (state == S_WRITE));

endmodule

// File: rtl/wgate_seq_top.sv
module wgate_seq_top
  import wgate_pkg::*;
#(
  parameter int WOB_BITS         = 32,
  parameter int WORD_WOBBLES     = 4836,
  parameter int WORDS_PER_BLOCK  = 4,
  parameter int SECTORS_PER_WORD = 4,
  parameter int LINK_BITS        = 8,
  parameter int CUT_BITS         = 8,
  parameter int START_WOBBLE     = 15,
  parameter int TRIM_TOL         = 5,
  parameter int TIMEOUT_WORDS    = 64,
  parameter int PSN_W            = 24,
  parameter int CNT_W            = 8,
  parameter int TRIM_W           = 5
) (
  input  logic                                       clk,
  input  logic                                       rstN,
  input  logic                                       startReq,
  input  logic [PSN_W-1:0]                           startPsn,
  input  logic [CNT_W-1:0]                           blockCount,
  input  logic                                       prevRecorded,
  input  logic signed [TRIM_W-1:0]                   startTrim,
  input  logic [$clog2(WORD_WOBBLES)-1:0]            wobbleNum,
  input  logic [$clog2(WOB_BITS)-1:0]                wobblePhase,
  input  logic                                       wordSync,
  input  logic [PSN_W-$clog2(SECTORS_PER_WORD)-1:0]  adipAddr,
  output logic                                       writeGate,
  output logic                                       linkWindow,
  output logic                                       dummyReq,
  output logic                                       errFlag
);

  seqCtl_t  ctl;
  seqFlag_t flags;

  wgate_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .flags     (flags),
    .ctl       (ctl),
    .writeGate (writeGate),
    .errFlag   (errFlag)
  );

  wgate_datapath #(
    .WOB_BITS         (WOB_BITS),
    .WORD_WOBBLES     (WORD_WOBBLES),
    .WORDS_PER_BLOCK  (WORDS_PER_BLOCK),
    .SECTORS_PER_WORD (SECTORS_PER_WORD),
    .LINK_BITS        (LINK_BITS),
    .CUT_BITS         (CUT_BITS),
    .START_WOBBLE     (START_WOBBLE),
    .TRIM_TOL         (TRIM_TOL),
    .TIMEOUT_WORDS    (TIMEOUT_WORDS),
    .PSN_W            (PSN_W),
    .CNT_W            (CNT_W),
    .TRIM_W           (TRIM_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .startPsn     (startPsn),
    .blockCount   (blockCount),
    .prevRecorded (prevRecorded),
    .startTrim    (startTrim),
    .wobbleNum    (wobbleNum),
    .wobblePhase  (wobblePhase),
    .wordSync     (wordSync),
    .adipAddr     (adipAddr),
    .writing      (writeGate),
    .flags        (flags),
    .linkWindow   (linkWindow),
    .dummyReq     (dummyReq)
  );

  p_link_in_gate_r4: assert property (@(posedge clk) disable iff (!rstN)
    linkWindow |-> writeGate);

  p_gate_starts_link_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(writeGate) |-> linkWindow);

  p_dummy_place_r6: assert property (@(posedge clk) disable iff (!rstN)
    dummyReq |-> (writeGate && !linkWindow));

endmodule

// File: tb/tb_wgate_seq_top.sv
module tb_wgate_seq_top;

  localparam int WOB  = 32;
  localparam int WW   = 20;
  localparam int WPB  = 4;
  localparam int TO   = 4;
  localparam int WORD = WOB * WW;
  localparam int BLK  = WORD * WPB;
  localparam int BASE = 100;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rstN = 1'b0;
  logic              startReq = 1'b0;
  logic [23:0]       startPsn = '0;
  logic [7:0]        blockCount = '0;
  logic              prevRecorded = 1'b1;
  logic signed [4:0] startTrim = '0;
  logic [4:0]        wobbleNum = '0;
  logic [4:0]        wobblePhase = '0;
  logic              wordSync = 1'b1;
  logic [21:0]       adipAddr = 22'(BASE);
  logic writeGate, linkWindow, dummyReq, errFlag;

  wgate_seq_top #(.WORD_WOBBLES(WW), .TIMEOUT_WORDS(TO)) dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .startPsn(startPsn),
    .blockCount(blockCount), .prevRecorded(prevRecorded), .startTrim(startTrim),
    .wobbleNum(wobbleNum), .wobblePhase(wobblePhase), .wordSync(wordSync),
    .adipAddr(adipAddr), .writeGate(writeGate), .linkWindow(linkWindow),
    .dummyReq(dummyReq), .errFlag(errFlag)
  );

  int vectors = 0;
  int miscompares = 0;
  int bc = 0;

  // behavioural reference: phase 0 idle, 1 waiting word, 2 waiting bit, 3 open
  int  mPhase = 0, mTgt = 0, mTotal = 0, mOpen = 0, mMiss = 0, mTrim = 0;
  bit  mErr = 0, mExt = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mErr = 0; mExt = 0; mOpen = 0; mMiss = 0;
    end else begin
      if (mPhase == 0) begin
        if (startReq) begin
          if ((int'(startPsn) % 16) != 0 || blockCount == 0 || startTrim > 5 || startTrim < -5) begin
            mErr = 1;
          end else begin
            mErr   = 0;
            mPhase = 1;
            mExt   = !prevRecorded;
            mTgt   = int'(startPsn) / 4 - (prevRecorded ? 0 : 4);
            mTotal = (int'(blockCount) + (prevRecorded ? 0 : 1)) * BLK;
            mTrim  = int'(startTrim);
            mMiss  = 0;
          end
        end
      end else if (mPhase == 1) begin
        if (wordSync) begin
          if (int'(adipAddr) == mTgt) mPhase = 2;
          else begin
            mMiss++;
            if (mMiss == TO) begin mErr = 1; mPhase = 0; end
          end
        end
      end else if (mPhase == 2) begin
        if (int'(wobbleNum) == 15 && int'(wobblePhase) == 24 + mTrim - 1) begin
          mPhase = 3; mOpen = 0;
        end
      end else begin
        if (mOpen == mTotal - 1) mPhase = 0;
        else mOpen++;
      end
    end
  end

  // observation records
  int rises = 0, riseWob = 0, risePhase = 0, riseAddr = 0;
  int openLen = 0, linkLen = 0, dummyLen = 0;
  bit prevGate = 0;

  always @(negedge clk) begin
    if (rstN) begin
      bit eGate, eLink, eDummy;
      eGate  = (mPhase == 3);
      eLink  = eGate && mOpen < 8;
      eDummy = eGate && mExt && mOpen >= 8 && mOpen < 8 + BLK;
      vectors++;
      if (writeGate !== eGate) begin
        miscompares++;
        $display("FAIL R5 writeGate actual=%0d expected=%0d t=%0t", writeGate, eGate, $time);
      end
      if (linkWindow !== eLink) begin
        miscompares++;
        $display("FAIL R4 linkWindow actual=%0d expected=%0d t=%0t", linkWindow, eLink, $time);
      end
      if (dummyReq !== eDummy) begin
        miscompares++;
        $display("FAIL R6 dummyReq actual=%0d expected=%0d t=%0t", dummyReq, eDummy, $time);
      end
      if (errFlag !== mErr) begin
        miscompares++;
        $display("FAIL R7 errFlag actual=%0d expected=%0d t=%0t", errFlag, mErr, $time);
      end
    end
    // environment: free-running wobble and word counters
    bc++;
    wobblePhase = 5'(bc % WOB);
    wobbleNum   = 5'((bc / WOB) % WW);
    wordSync    = (bc % WORD) == 0;
    adipAddr    = 22'(BASE + bc / WORD);
    if (writeGate && !prevGate) begin
      rises++;
      riseWob = int'(wobbleNum); risePhase = int'(wobblePhase); riseAddr = int'(adipAddr);
      openLen = 0; linkLen = 0; dummyLen = 0;
    end
    if (writeGate) begin
      openLen++;
      if (linkWindow) linkLen++;
      if (dummyReq) dummyLen++;
    end
    prevGate = writeGate;
  end

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic request(int psn, int m, bit prev, int trim);
    @(negedge clk);
    startPsn = 24'(psn); blockCount = 8'(m); prevRecorded = prev; startTrim = 5'(trim);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    #1;
  endtask

  function automatic int aheadWord(int gap);
    return ((int'(adipAddr) + gap + 3) / 4) * 4;
  endfunction

  task automatic runCheck(int m, bit prev, int trim, bit poke);
    int tgt, first, r0;
    tgt   = aheadWord(2);
    first = prev ? tgt : tgt + 4;
    r0    = rises;
    request(first * 4, m, prev, trim);
    chk(errFlag == 1'b0, "R10", "errFlag after accepted request", errFlag, 0);
    while (rises == r0) tick();
    if (poke) begin
      repeat (100) tick();
      request(aheadWord(2) * 4 + 64, 3, 1'b0, 2);
    end
    while (writeGate) tick();
    chk(riseAddr == tgt, "R2", "word address at opening", riseAddr, tgt);
    chk(riseWob == 15, "R3", "wobble at opening", riseWob, 15);
    chk(risePhase == 24 + trim, "R3", "phase at opening", risePhase, 24 + trim);
    chk(openLen == (m + (prev ? 0 : 1)) * BLK, "R5", "gate length", openLen, (m + (prev ? 0 : 1)) * BLK);
    chk(linkLen == 8, "R4", "linking window length", linkLen, 8);
    chk(dummyLen == (prev ? 0 : BLK), "R6", "dummy window length", dummyLen, prev ? 0 : BLK);
    if (poke) begin
      r0 = rises;
      repeat (3 * WORD) tick();
      chk(rises == r0, "R8", "openings after busy request", rises - r0, 0);
      chk(errFlag == 1'b0, "R8", "errFlag after busy request", errFlag, 0);
    end
  endtask

  task automatic refuseCheck(int psn, int m, int trim);
    int r0;
    r0 = rises;
    request(psn, m, 1'b1, trim);
    chk(errFlag == 1'b1, "R1", "errFlag after refused request", errFlag, 1);
    repeat (2 * WORD) tick();
    chk(rises == r0, "R1", "openings after refused request", rises - r0, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    tick();
    // R9: quiet after reset
    chk(writeGate == 0, "R9", "writeGate after reset", writeGate, 0);
    chk(linkWindow == 0, "R9", "linkWindow after reset", linkWindow, 0);
    chk(dummyReq == 0, "R9", "dummyReq after reset", dummyReq, 0);
    chk(errFlag == 0, "R9", "errFlag after reset", errFlag, 0);

    runCheck(1, 1'b1, 0, 1'b0);
    runCheck(2, 1'b0, 5, 1'b0);
    runCheck(1, 1'b1, -5, 1'b1);

    refuseCheck(aheadWord(2) * 4, 1, 6);
    runCheck(1, 1'b1, 3, 1'b0);
    refuseCheck(aheadWord(2) * 4 + 4, 1, 0);
    refuseCheck(aheadWord(2) * 4, 0, 0);
    refuseCheck(aheadWord(2) * 4, 1, -6);

    begin
      int r0;
      r0 = rises;
      request(((int'(adipAddr) - 8) / 4) * 4 * 4, 1, 1'b1, 0);
      chk(errFlag == 1'b0, "R10", "errFlag after accepted stale request", errFlag, 0);
      repeat ((TO + 2) * WORD) tick();
      chk(errFlag == 1'b1, "R7", "errFlag after timeout", errFlag, 1);
      chk(rises == r0, "R7", "openings after timeout", rises - r0, 0);
    end

    runCheck(3, 1'b0, -2, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(150000 * 10);
    miscompares++;
    $display("FAIL watchdog run did not complete actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule